// File: doc/BRIEF.md
# SerDes Direction and Power-Mode Controller

This block is the control plane of a 12-bit link endpoint that can run either as a serializer or as a deserializer. A direction pin chooses the role. The block enables exactly one of the two datapaths. When the role changes, it inserts a short dead period so that both paths are never enabled together. It also drives the inverse of the direction pin, so a master device can steer the direction pin of a slave.

A two-bit mode-select input picks one of three parallel-rate sub-ranges between 5 MHz and 56 MHz, or power-down when both bits are low. In power-down the block turns off the PLL, the differential input receivers and the output drivers, and it holds the internal logic in a synchronous reset. After power-down ends, the reset is released after a short fixed delay. The PLL enable then stays low until an activity detector, running on an always-on housekeeping clock, has confirmed that the reference clock is toggling. The selected range is passed out as a code for the frequency-tuning logic.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: Once a direction has settled, `dir_in` = 1 asserts `ser_en` only, and `dir_in` = 0 asserts `des_en` only.
- R2: `dir_out` is always the logical inverse of `dir_in`, with no clock delay.
- R3: After `dir_in` changes, `ser_en` and `des_en` are both low for exactly 4 housekeeping cycles before the enable for the new direction rises. The two are never high together.
- R4: When `mode_sel` = 2'b00 is sampled on a clock edge, then after that edge `int_rst_n`, `pll_en`, `in_en`, `out_oe`, `ser_en` and `des_en` are all 0.
- R5: After `mode_sel` leaves 2'b00, `int_rst_n` is still 0 after the first clock edge and is 1 after the second. `in_en` and `out_oe` follow `int_rst_n`.
- R6: `ckref_valid` is set at the end of the second consecutive 256-cycle window that counted at least 4 reference-clock rising edges. `pll_en` rises in the same cycle as `ckref_valid` while `int_rst_n` is 1.
- R7: A 256-cycle window with no reference-clock edge clears `ckref_valid`, and `pll_en` falls in the same cycle.
- R8: Power-down clears `ckref_valid`. After power-down ends, `pll_en` stays 0 until two more qualifying windows have passed.
- R9: `range_code` equals `mode_sel` for all four codes. Changing between non-zero codes does not drop `int_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hk_clk | input | 1 | Always-on housekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk | input | 1 | Parallel reference clock whose activity is monitored |
| dir_in | input | 1 | Role select: 1 serializer, 0 deserializer |
| mode_sel | input | 2 | 2'b00 power-down, other codes select a rate sub-range |
| dir_out | output | 1 | Inverse of dir_in, for chaining to a peer |
| range_code | output | 2 | Selected rate sub-range code |
| ser_en | output | 1 | Serializer path enable |
| des_en | output | 1 | Deserializer path enable |
| pll_en | output | 1 | PLL enable |
| out_oe | output | 1 | Differential and single-ended output driver enable |
| in_en | output | 1 | Differential input receiver enable |
| int_rst_n | output | 1 | Synchronous internal reset, active low |
| ckref_valid | output | 1 | Reference clock judged present |

## Verification
The assertions check on every cycle that a path enable only rises after a cycle with both paths off. They also check that an enable agrees with the direction sampled the cycle before, that all enables are off one edge after a power-down code, and that the internal reset only releases with a non-zero mode. For the detector they check that the valid flag changes only at a window boundary or under internal reset, and that the PLL enable never rises in the cycle reset is released. Only the bench scenarios can show the exact four-cycle dead period, the two-edge reset release and the window-count latencies: acquiring the reference clock, losing it when it stops, and reacquiring it after a restart and after power-down.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [0:0] {
    DS_GAP    = 1'b0,
    DS_ACTIVE = 1'b1
  } dir_state_e;

  localparam logic [1:0] MODE_POWER_DOWN = 2'b00;
endpackage

// File: rtl/sdc_pwr_seq.sv
module sdc_pwr_seq #(
  parameter int RST_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  output logic       int_rst_n_o
);
  import sdc_pkg::*;

  localparam int CW = (RST_DELAY > 0) ? $clog2(RST_DELAY + 1) : 1;
  localparam logic [CW-1:0] CNT_DONE = CW'(RST_DELAY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pd;

  assign pd = (mode_sel == MODE_POWER_DOWN);

  always_comb begin
    if (pd)                   cnt_d = '0;
    else if (cnt_q == CNT_DONE) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign int_rst_n_o = (cnt_q == CNT_DONE) && (RST_DELAY > 0 || !pd);

  // R4: a power-down code forces internal reset after the next edge
  p_pd_enters_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_POWER_DOWN) |=> !int_rst_n_o);

  // R5: reset is only released when the previous cycle had a live mode
  p_release_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst_n_o) |-> $past(mode_sel != MODE_POWER_DOWN));
endmodule

// File: rtl/sdc_dir_seq.sv
module sdc_dir_seq #(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dir_in,
  output logic ser_en_o,
  output logic des_en_o
);
  import sdc_pkg::*;

  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  logic [1:0]  dir_sync_q;
  logic        dir_s;
  dir_state_e  state_q, state_d;
  logic        cur_q, cur_d;
  logic [GW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_sync_q <= '0;
    else        dir_sync_q <= {dir_sync_q[0], dir_in};
  end
  assign dir_s = dir_sync_q[1];

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    if (clr) begin
      state_d = DS_GAP;
      cur_d   = dir_s;
      cnt_d   = '0;
    end else begin
      case (state_q)
        DS_GAP: begin
          cur_d = dir_s;
          if (dir_s != cur_q) begin
            cnt_d = '0;
          end else if (cnt_q == GAP_LAST) begin
            state_d = DS_ACTIVE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        DS_ACTIVE: begin
          if (dir_s != cur_q) begin
            state_d = DS_GAP;
            cur_d   = dir_s;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = DS_GAP;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_GAP;
      cur_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ser_en_o = (state_q == DS_ACTIVE) &&  cur_q;
  assign des_en_o = (state_q == DS_ACTIVE) && !cur_q;

  // R3: an enable only rises after a cycle with both paths off
  p_ser_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en_o) |-> $past(!ser_en_o && !des_en_o));
  p_des_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(des_en_o) |-> $past(!ser_en_o && !des_en_o));

  // R1: the active enable agrees with the direction sampled one cycle earlier
  p_ser_follows_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en_o |-> $past(dir_s));
  p_des_follows_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    des_en_o |-> !$past(dir_s));
endmodule

// File: rtl/sdc_refclk_det.sv
module sdc_refclk_det #(
  parameter int WIN_CYCLES    = 256,
  parameter int MIN_EDGES     = 4,
  parameter int VALID_WINDOWS = 2,
  parameter int LOST_WINDOWS  = 1
) (
  input  logic hk_clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic clr,
  output logic valid_o
);
  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam int VW = $clog2(VALID_WINDOWS + 1);
  localparam int LW = $clog2(LOST_WINDOWS + 1);
  localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYCLES - 1);
  localparam logic [EW-1:0] EDGE_MAX  = EW'(MIN_EDGES);
  localparam logic [VW-1:0] GOOD_NEED = VW'(VALID_WINDOWS);
  localparam logic [LW-1:0] LOST_NEED = LW'(LOST_WINDOWS);

  // reference-domain toggle, one flip per rising edge
  logic ref_tog_q;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_tog_q <= 1'b0;
    else        ref_tog_q <= ~ref_tog_q;
  end

  // two synchronizer flops plus one history flop for edge detect
  logic [2:0] sync_q;
  logic       ref_edge;
  always_ff @(posedge hk_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_tog_q};
  end
  assign ref_edge = sync_q[2] ^ sync_q[1];

  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] edges_q, edges_d, edges_inc;
  logic [VW-1:0] good_q, good_d, good_inc;
  logic [LW-1:0] empty_q, empty_d, empty_inc;
  logic          valid_q, valid_d;
  logic          win_end, win_good, win_empty;

  assign win_end   = (win_q == WIN_LAST);
  assign edges_inc = (ref_edge && edges_q != EDGE_MAX) ? edges_q + 1'b1 : edges_q;
  assign win_good  = (edges_inc == EDGE_MAX);
  assign win_empty = (edges_inc == '0);
  assign good_inc  = (good_q  == GOOD_NEED) ? good_q  : good_q  + 1'b1;
  assign empty_inc = (empty_q == LOST_NEED) ? empty_q : empty_q + 1'b1;

  always_comb begin
    win_d   = win_q;
    edges_d = edges_q;
    good_d  = good_q;
    empty_d = empty_q;
    valid_d = valid_q;
    if (clr) begin
      win_d   = '0;
      edges_d = '0;
      good_d  = '0;
      empty_d = '0;
      valid_d = 1'b0;
    end else if (win_end) begin
      win_d   = '0;
      edges_d = '0;
      good_d  = win_good  ? good_inc  : '0;
      empty_d = win_empty ? empty_inc : '0;
      if (win_good && good_inc == GOOD_NEED)         valid_d = 1'b1;
      else if (win_empty && empty_inc == LOST_NEED)  valid_d = 1'b0;
    end else begin
      win_d   = win_q + 1'b1;
      edges_d = edges_inc;
    end
  end

  always_ff @(posedge hk_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      edges_q <= '0;
      good_q  <= '0;
      empty_q <= '0;
      valid_q <= 1'b0;
    end else begin
      win_q   <= win_d;
      edges_q <= edges_d;
      good_q  <= good_d;
      empty_q <= empty_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  // R6: validity is only granted at a window boundary
  p_valid_at_window_end_r6: assert property (@(posedge hk_clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(win_end && !clr));
  // R7: validity is only withdrawn at a window boundary or by internal reset
  p_lost_at_window_end_r7: assert property (@(posedge hk_clk) disable iff (!rst_n)
    $fell(valid_o) |-> $past(win_end || clr));
  // R8: internal reset clears the detector
  p_clr_clears_valid_r8: assert property (@(posedge hk_clk) disable iff (!rst_n)
    clr |=> !valid_o);
endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl #(
  parameter int WIN_CYCLES    = 256,
  parameter int MIN_EDGES     = 4,
  parameter int VALID_WINDOWS = 2,
  parameter int LOST_WINDOWS  = 1,
  parameter int DIR_GAP       = 4,
  parameter int RST_DELAY     = 2
) (
  input  logic       hk_clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       dir_in,
  input  logic [1:0] mode_sel,
  output logic       dir_out,
  output logic [1:0] range_code,
  output logic       ser_en,
  output logic       des_en,
  output logic       pll_en,
  output logic       out_oe,
  output logic       in_en,
  output logic       int_rst_n,
  output logic       ckref_valid
);
  import sdc_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge hk_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic live;
  logic seq_ser, seq_des;
  logic det_valid;

  sdc_pwr_seq #(.RST_DELAY(RST_DELAY)) u_pwr (
    .clk         (hk_clk),
    .rst_n       (rst_n_s),
    .mode_sel    (mode_sel),
    .int_rst_n_o (live)
  );

  sdc_dir_seq #(.GAP_CYCLES(DIR_GAP)) u_dir (
    .clk      (hk_clk),
    .rst_n    (rst_n_s),
    .clr      (!live),
    .dir_in   (dir_in),
    .ser_en_o (seq_ser),
    .des_en_o (seq_des)
  );

  sdc_refclk_det #(
    .WIN_CYCLES    (WIN_CYCLES),
    .MIN_EDGES     (MIN_EDGES),
    .VALID_WINDOWS (VALID_WINDOWS),
    .LOST_WINDOWS  (LOST_WINDOWS)
  ) u_det (
    .hk_clk  (hk_clk),
    .rst_n   (rst_n_s),
    .ref_clk (ref_clk),
    .clr     (!live),
    .valid_o (det_valid)
  );

  assign dir_out     = ~dir_in;
  assign range_code  = mode_sel;
  assign int_rst_n   = live;
  assign ckref_valid = det_valid;
  assign pll_en      = live && det_valid;
  assign in_en       = live;
  assign out_oe      = live;
  assign ser_en      = live && seq_ser;
  assign des_en      = live && seq_des;

  // R4: a power-down code quiets every enable one edge later
  p_pd_quiet_r4: assert property (@(posedge hk_clk) disable iff (!rst_n_s)
    (mode_sel == MODE_POWER_DOWN) |=> (!pll_en && !ser_en && !des_en && !out_oe && !in_en));
  // R8: the PLL never comes up in the same cycle internal reset releases
  p_pll_not_at_release_r8: assert property (@(posedge hk_clk) disable iff (!rst_n_s)
    $rose(pll_en) |-> $past(int_rst_n));
  // R3: both path enables never high together
  p_paths_exclusive_r3: assert property (@(posedge hk_clk) disable iff (!rst_n_s)
    !(ser_en && des_en));
endmodule

// File: tb/serdes_mode_ctrl_test.sv
module serdes_mode_ctrl_test;
  localparam int WIN = 256;

  logic       hk_clk = 1'b0;
  logic       rst_n;
  logic       ref_clk = 1'b0;
  logic       ref_run;
  logic       dir_in;
  logic [1:0] mode_sel;
  logic       dir_out, ser_en, des_en, pll_en, out_oe, in_en, int_rst_n, ckref_valid;
  logic [1:0] range_code;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  serdes_mode_ctrl uut (
    .hk_clk(hk_clk), .rst_n(rst_n), .ref_clk(ref_clk), .dir_in(dir_in),
    .mode_sel(mode_sel), .dir_out(dir_out), .range_code(range_code),
    .ser_en(ser_en), .des_en(des_en), .pll_en(pll_en), .out_oe(out_oe),
    .in_en(in_en), .int_rst_n(int_rst_n), .ckref_valid(ckref_valid)
  );

  always #5 hk_clk = ~hk_clk;

  initial begin
    forever begin
      #20;
      if (ref_run) ref_clk = ~ref_clk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // cycles until ckref_valid reaches lvl; returns -1 on timeout
  task automatic wait_valid(input logic lvl, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge hk_clk);
      if (ckref_valid == lvl) begin
        n = i;
        break;
      end
    end
  endtask

  // flip direction, count dead cycles until the new enable is up
  task automatic toggle_dir(input logic nd, input string req);
    int dead;
    int both;
    bit up;
    dead = 0; both = 0; up = 0;
    dir_in = nd;
    for (int i = 0; i < 20 && !up; i++) begin
      @(negedge hk_clk);
      if (ser_en && des_en) both++;
      if (!ser_en && !des_en) dead++;
      if (nd ? ser_en : des_en) up = 1;
    end
    check({req, " R3 dead cycles"}, dead, 4);
    check({req, " R3 never both"}, both, 0);
    check({req, " R1 ser_en"}, int'(ser_en), int'(nd));
    check({req, " R1 des_en"}, int'(des_en), int'(!nd));
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; ref_run = 1'b0; dir_in = 1'b1; mode_sel = 2'b01;
    repeat (3) @(negedge hk_clk);
    // reset state (R4 outputs quiet)
    check("R4 reset int_rst_n", int'(int_rst_n), 0);
    check("R4 reset pll_en", int'(pll_en), 0);
    check("R4 reset out_oe", int'(out_oe), 0);
    check("R4 reset ser_en", int'(ser_en), 0);
    rst_n = 1'b1;
    repeat (12) @(negedge hk_clk);
    check("R5 live int_rst_n", int'(int_rst_n), 1);
    check("R5 live in_en", int'(in_en), 1);
    check("R5 live out_oe", int'(out_oe), 1);
    check("R1 initial ser_en", int'(ser_en), 1);
    check("R1 initial des_en", int'(des_en), 0);
    check("R8 no ref pll_en", int'(pll_en), 0);

    // R2 sweep over both levels
    for (int v = 0; v < 2; v++) begin
      dir_in = v[0];
      #1;
      check("R2 dir_out", int'(dir_out), int'(!v[0]));
    end
    dir_in = 1'b1;
    repeat (12) @(negedge hk_clk);

    // R6 acquire reference
    ref_run = 1'b1;
    wait_valid(1'b1, 3 * WIN + 12, n);
    check("R6 valid acquired", int'(n > 0), 1);
    check("R6 not before a full window", int'(n > WIN - 10), 1);
    check("R6 pll_en with valid", int'(pll_en), 1);

    // R3/R1 direction toggles
    toggle_dir(1'b0, "to des");
    toggle_dir(1'b1, "to ser");
    toggle_dir(1'b0, "to des again");

    // R9 range sweep across live codes
    for (int c = 1; c < 4; c++) begin
      mode_sel = c[1:0];
      @(negedge hk_clk);
      check("R9 range_code", int'(range_code), c);
      check("R9 stays live", int'(int_rst_n), 1);
    end

    // R4 power-down
    mode_sel = 2'b00;
    #1;
    check("R9 range_code pd", int'(range_code), 0);
    @(negedge hk_clk);
    check("R4 pd int_rst_n", int'(int_rst_n), 0);
    check("R4 pd pll_en", int'(pll_en), 0);
    check("R4 pd in_en", int'(in_en), 0);
    check("R4 pd out_oe", int'(out_oe), 0);
    check("R4 pd des_en", int'(des_en), 0);
    repeat (4) @(negedge hk_clk);
    check("R8 pd clears valid", int'(ckref_valid), 0);

    // R5 exit timing
    mode_sel = 2'b10;
    @(negedge hk_clk);
    check("R5 exit after 1 edge", int'(int_rst_n), 0);
    @(negedge hk_clk);
    check("R5 exit after 2 edges", int'(int_rst_n), 1);
    check("R5 out_oe follows", int'(out_oe), 1);
    check("R8 pll waits", int'(pll_en), 0);
    wait_valid(1'b1, 3 * WIN + 12, n);
    check("R8 reacquired after pd", int'(n > WIN - 10), 1);
    check("R8 pll_en back", int'(pll_en), 1);

    // R7 reference stops
    ref_run = 1'b0;
    wait_valid(1'b0, 2 * WIN + 12, n);
    check("R7 valid lost", int'(n > 0), 1);
    check("R7 pll_en drops", int'(pll_en), 0);
    repeat (WIN) @(negedge hk_clk);
    check("R7 stays lost", int'(ckref_valid), 0);

    // R6 restart
    ref_run = 1'b1;
    wait_valid(1'b1, 3 * WIN + 12, n);
    check("R6 restart valid", int'(n > WIN - 10), 1);
    check("R6 restart pll_en", int'(pll_en), 1);

    finish_run();
  end
endmodule